// File: doc/BRIEF.md
# Call-Charge Tone Follower

This block decides whether a metering tone at the selected call-charge frequency is present on a line. The input is the squared-up output of an external level detector and comparator. The block times every input cycle against a fixed 3.579545 MHz reference clock. A cycle counts as good when its length in reference ticks lies inside a tolerance band around the nominal period of the selected system. Cycles are grouped into packets of 32, and each packet is judged good or bad as a whole.

Each packet decision is issued as a one-clock strobe together with a good/bad flag, so that downstream logic (for example a cumulative-window detector) can consume it. The same decisions drive an active-low follower output that traces the envelope of a valid tone. A hysteresis of two packets keeps one noisy packet from toggling the follower. If edges stop arriving, a packet timer closes the open packet as bad, so the follower still releases when the tone is gone.

Top module: `charge_tone_follower`

## Requirements
- R1: While reset is held and directly after it, `toneN` is 1, `pktStrobe` is 0 and `pktGood` is 0.
- R2: With `sel12`=1 the nominal period is 298 reference clocks and the good band is 290..306 clocks. With `sel12`=0 the nominal period is 224 clocks and the band is 218..230 clocks. A measured cycle is the number of clocks between two successive synchronised rising edges of `sigIn`. A cycle is good only when that count lies inside the band.
- R3: A packet closes on its 32nd measured cycle. At the close, `pktStrobe` is high for exactly one clock, and `pktGood` is 1 when at least 30 of the 32 cycles were good and 0 otherwise. `pktGood` holds its value until the next strobe.
- R4: The first rising edge after reset, and the first rising edge after the period count has passed the band's upper limit, only starts a new measurement. That edge closes no cycle.
- R5: When no packet completes, the packet timer closes the packet as bad. The timeout is 32 times the upper band limit: 7360 clocks with `sel12`=0 and 9792 clocks with `sel12`=1. With no input edges, successive strobes are exactly that many clocks apart.
- R6: `toneN` falls at the strobe of the second consecutive good packet. It does not fall after a single good packet.
- R7: `toneN` rises at the strobe of the second consecutive bad packet. A single bad packet leaves it low.
- R8: `toneN` changes only in a clock cycle in which `pktStrobe` is high.
- R9: A tone at the other system's frequency produces only bad packets and leaves `toneN` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 3.579545 MHz nominal |
| rstN | input | 1 | Asynchronous active-low reset |
| sel12 | input | 1 | System select: 1 selects 12 kHz, 0 selects 16 kHz (tie high when unused) |
| sigIn | input | 1 | Limited one-bit tone signal, asynchronous to clk |
| toneN | output | 1 | Follower output, low while a valid tone is detected |
| pktStrobe | output | 1 | One-clock pulse at every packet decision |
| pktGood | output | 1 | Decision of the last closed packet, 1 = good |

## Verification
The hardest cases to reach are the packet threshold cases, where a packet must hold exactly 30 or exactly 29 good cycles. The packet boundaries are internal and are only revealed by the strobe. The bench therefore first lets the input stay silent long enough for the period counter to pass its upper limit. It then starts each tone burst directly after a timeout strobe. Because the first edge only re-arms the measurement, every following group of 32 queued periods falls into one known packet. The bench then places a chosen number of short periods at the head of each packet.

// File: rtl/tf_pkg.sv
package tf_pkg;

  // Strobes issued by the control to the datapath counters.
  typedef struct packed {
    logic countCycle;   // a measured cycle ends now
    logic countGood;    // ... and it lies inside the band
    logic closePacket;  // clear packet counters and timer
  } tfStrobes_t;

  // Conditions reported by the datapath to the control.
  typedef struct packed {
    logic rise;        // synchronised rising edge this cycle
    logic inBand;      // current period count is inside the band
    logic overflow;    // period count passed the upper limit
    logic lastCycle;   // open packet already holds CYCLES-1 cycles
    logic goodAtMin;   // good count already reaches the minimum
    logic goodShort;   // good count is one below the minimum
    logic timeout;     // packet timer reaches its last tick
  } tfStatus_t;

endpackage

// File: rtl/tf_datapath.sv
module tf_datapath
  import tf_pkg::*;
#(
  parameter int NOM16       = 224,
  parameter int NOM12       = 298,
  parameter int TOL_PCT     = 3,
  parameter int CYCLES      = 32,
  parameter int MIN_GOOD    = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sel12,
  input  logic       sigIn,
  input  tfStrobes_t strobes,
  output tfStatus_t  status
);

  localparam int LO16  = NOM16 - (NOM16 * TOL_PCT) / 100;
  localparam int HI16  = NOM16 + (NOM16 * TOL_PCT) / 100;
  localparam int LO12  = NOM12 - (NOM12 * TOL_PCT) / 100;
  localparam int HI12  = NOM12 + (NOM12 * TOL_PCT) / 100;
  localparam int PMAX  = (HI12 > HI16) ? HI12 : HI16;
  localparam int PW    = $clog2(PMAX + 2);
  localparam int TMO16 = HI16 * CYCLES;
  localparam int TMO12 = HI12 * CYCLES;
  localparam int TMAX  = (TMO12 > TMO16) ? TMO12 : TMO16;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int CW    = $clog2(CYCLES + 1);

  // Synchroniser plus one history flop for edge detection.
  logic [SYNC_STAGES:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], sigIn};
  end

  logic riseNow;
  assign riseNow = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  // Band limits and timeout for the selected system.
  logic [PW-1:0] limLo, limHi;
  logic [TW-1:0] tmoLast;
  assign limLo   = sel12 ? PW'(LO12) : PW'(LO16);
  assign limHi   = sel12 ? PW'(HI12) : PW'(HI16);
  assign tmoLast = sel12 ? TW'(TMO12 - 1) : TW'(TMO16 - 1);

  // Period counter, saturating one past the upper limit.
  logic [PW-1:0] periodCnt;
  logic          overNow;
  assign overNow = periodCnt > limHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         periodCnt <= PW'(PMAX + 1);
    else if (riseNow)  periodCnt <= PW'(1);
    else if (!overNow) periodCnt <= periodCnt + PW'(1);
  end

  // Packet counters and packet timer.
  logic [CW-1:0] cycleCnt, goodCnt;
  logic [TW-1:0] tCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt <= '0;
      goodCnt  <= '0;
      tCnt     <= '0;
    end else if (strobes.closePacket) begin
      cycleCnt <= '0;
      goodCnt  <= '0;
      tCnt     <= '0;
    end else begin
      tCnt <= tCnt + TW'(1);
      if (strobes.countCycle) cycleCnt <= cycleCnt + CW'(1);
      if (strobes.countGood)  goodCnt  <= goodCnt + CW'(1);
    end
  end

  assign status.rise      = riseNow;
  assign status.inBand    = (periodCnt >= limLo) && !overNow;
  assign status.overflow  = overNow;
  assign status.lastCycle = cycleCnt == CW'(CYCLES - 1);
  assign status.goodAtMin = goodCnt >= CW'(MIN_GOOD);
  assign status.goodShort = goodCnt == CW'(MIN_GOOD - 1);
  assign status.timeout   = tCnt >= tmoLast;

  // Checks
  assert_period_sat_R2: assert property (@(posedge clk) disable iff (!rstN)
    periodCnt <= PW'(PMAX + 1));

  assert_cycle_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    cycleCnt < CW'(CYCLES));

  assert_good_le_cycles_R3: assert property (@(posedge clk) disable iff (!rstN)
    goodCnt <= cycleCnt);

  assert_timeout_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    tCnt < TW'(TMAX));

endmodule

// File: rtl/tf_control.sv
module tf_control
  import tf_pkg::*;
#(
  parameter int CONFIRM = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  tfStatus_t  status,
  output tfStrobes_t strobes,
  output logic       toneN,
  output logic       pktStrobe,
  output logic       pktGood
);

  localparam int RW = $clog2(CONFIRM + 1);

  // A measurement is armed once an edge has started it and the count has not
  // run past the upper limit since.
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                armed <= 1'b0;
    else if (status.rise)     armed <= 1'b1;
    else if (status.overflow) armed <= 1'b0;
  end

  logic fullClose, pktIsGood;
  assign strobes.countCycle  = status.rise & armed;
  assign strobes.countGood   = strobes.countCycle & status.inBand;
  assign fullClose           = strobes.countCycle & status.lastCycle;
  assign strobes.closePacket = fullClose | status.timeout;
  assign pktIsGood = fullClose &
                     (status.goodAtMin | (status.goodShort & status.inBand));

  // Packet runs and follower with hysteresis.
  logic [RW-1:0] goodRun, badRun, goodNext, badNext;
  assign goodNext = (goodRun == RW'(CONFIRM)) ? goodRun : goodRun + RW'(1);
  assign badNext  = (badRun  == RW'(CONFIRM)) ? badRun  : badRun  + RW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktStrobe <= 1'b0;
      pktGood   <= 1'b0;
      goodRun   <= '0;
      badRun    <= '0;
      toneN     <= 1'b1;
    end else begin
      pktStrobe <= strobes.closePacket;
      if (strobes.closePacket) begin
        pktGood <= pktIsGood;
        if (pktIsGood) begin
          goodRun <= goodNext;
          badRun  <= '0;
          if (goodNext >= RW'(CONFIRM)) toneN <= 1'b0;
        end else begin
          badRun  <= badNext;
          goodRun <= '0;
          if (badNext >= RW'(CONFIRM)) toneN <= 1'b1;
        end
      end
    end
  end

  // Checks
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    pktStrobe |=> !pktStrobe);

  assert_follow_on_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(toneN) |-> pktStrobe);

  assert_fall_on_good_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(toneN) |-> pktGood);

  assert_rise_on_bad_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toneN) |-> !pktGood);

  assert_armed_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (status.rise && !armed) |=> !pktStrobe || $past(status.timeout));

endmodule

// File: rtl/charge_tone_follower.sv
module charge_tone_follower
  import tf_pkg::*;
#(
  parameter int NOM16       = 224,
  parameter int NOM12       = 298,
  parameter int TOL_PCT     = 3,
  parameter int CYCLES      = 32,
  parameter int MIN_GOOD    = 30,
  parameter int SYNC_STAGES = 2,
  parameter int CONFIRM     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sel12,
  input  logic sigIn,
  output logic toneN,
  output logic pktStrobe,
  output logic pktGood
);

  tfStrobes_t strobes;
  tfStatus_t  status;

  tf_datapath #(
    .NOM16(NOM16), .NOM12(NOM12), .TOL_PCT(TOL_PCT), .CYCLES(CYCLES),
    .MIN_GOOD(MIN_GOOD), .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .sel12(sel12), .sigIn(sigIn),
    .strobes(strobes), .status(status)
  );

  tf_control #(
    .CONFIRM(CONFIRM)
  ) i_control (
    .clk(clk), .rstN(rstN), .status(status), .strobes(strobes),
    .toneN(toneN), .pktStrobe(pktStrobe), .pktGood(pktGood)
  );

endmodule

// File: tb/test_charge_tone_follower.sv
`timescale 1ns/1ps
module test_charge_tone_follower;

  logic clk = 1'b0;
  logic rstN, sel12, sigIn;
  logic toneN, pktStrobe, pktGood;

  always #2 clk = ~clk;   // 250 MHz

  charge_tone_follower i_charge_tone_follower (
    .clk(clk), .rstN(rstN), .sel12(sel12), .sigIn(sigIn),
    .toneN(toneN), .pktStrobe(pktStrobe), .pktGood(pktGood)
  );

  localparam int P16 = 224, P12 = 298, PKT = 32;
  localparam int TMO16 = 230 * PKT, TMO12 = 306 * PKT;

  int checks = 0, fails = 0, cyc = 0, lastStamp = 0, r8Bad = 0;
  logic prevToneN = 1'b1;
  int periodQ[$];

  always @(posedge clk) cyc++;

  // R8 monitor: follower may only move together with a strobe.
  always @(negedge clk) begin
    if (rstN === 1'b1 && toneN !== prevToneN && pktStrobe !== 1'b1) r8Bad++;
    prevToneN = toneN;
  end

  // Tone generator: each queued value is one period, rising edge first.
  initial begin : toneGen
    sigIn = 1'b0;
    forever begin
      int p;
      @(negedge clk);
      if (periodQ.size() > 0) begin
        p = periodQ.pop_front();
        sigIn = 1'b1;
        repeat (p / 2) @(negedge clk);
        sigIn = 1'b0;
        repeat (p - p / 2 - 1) @(negedge clk);
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitStrobe(output int gap);
    do @(negedge clk); while (pktStrobe !== 1'b1);
    gap = cyc - lastStamp;
    lastStamp = cyc;
  endtask

  task automatic pushPacket(input int period, input int nBad, input int badPeriod);
    for (int i = 0; i < PKT; i++) periodQ.push_back(i < nBad ? badPeriod : period);
  endtask

  task automatic testReset();
    chk("R1", "toneN in reset", toneN, 1);
    chk("R1", "pktStrobe in reset", pktStrobe, 0);
    chk("R1", "pktGood in reset", pktGood, 0);
  endtask

  task automatic testIdle();
    int g;
    waitStrobe(g);
    chk("R5", "idle packet good flag", pktGood, 0);
    chk("R5", "idle follower", toneN, 1);
    waitStrobe(g);
    chk("R5", "idle strobe spacing 16k", g, TMO16);
  endtask

  task automatic testToneOn16();
    int g, start;
    start = cyc;
    for (int k = 0; k < 3; k++) pushPacket(P16, 0, 0);
    periodQ.push_back(P16);
    waitStrobe(g);
    chk("R4", "arming edge not counted", int'((cyc - start) >= 32*P16 && (cyc - start) <= 32*P16 + 8), 1);
    chk("R3", "first tone packet good", pktGood, 1);
    chk("R6", "one good packet keeps follower high", toneN, 1);
    waitStrobe(g);
    chk("R3", "packet spacing 32 periods", g, 32 * P16);
    chk("R3", "second tone packet good", pktGood, 1);
    chk("R6", "follower low after two good", toneN, 0);
    waitStrobe(g);
    chk("R3", "third tone packet good", pktGood, 1);
    waitStrobe(g);
    chk("R5", "silent packet bad", pktGood, 0);
    chk("R7", "one bad packet keeps follower low", toneN, 0);
    waitStrobe(g);
    chk("R5", "timeout spacing after tone", g, TMO16);
    chk("R7", "follower high after two bad", toneN, 1);
  endtask

  task automatic testThreshold();
    int g;
    pushPacket(P16, 0, 0);
    pushPacket(P16, 0, 0);
    pushPacket(P16, 2, 200);
    pushPacket(P16, 3, 200);
    pushPacket(P16, 3, 200);
    periodQ.push_back(P16);
    waitStrobe(g);
    chk("R6", "threshold run pkt1 follower", toneN, 1);
    waitStrobe(g);
    chk("R6", "threshold run pkt2 follower", toneN, 0);
    waitStrobe(g);
    chk("R3", "30 of 32 good is good", pktGood, 1);
    waitStrobe(g);
    chk("R3", "29 of 32 good is bad", pktGood, 0);
    chk("R7", "single bad packet holds follower", toneN, 0);
    waitStrobe(g);
    chk("R3", "second 29-good packet bad", pktGood, 0);
    chk("R7", "release after two bad", toneN, 1);
    waitStrobe(g);   // silent packet, realigns timer
  endtask

  task automatic testWrongRate();
    int g;
    for (int i = 0; i < 50; i++) periodQ.push_back(P12);
    waitStrobe(g);
    chk("R9", "12k tone in 16k mode bad", pktGood, 0);
    chk("R9", "off-rate spacing is timeout", g, TMO16);
    waitStrobe(g);
    chk("R9", "second off-rate packet bad", pktGood, 0);
    chk("R9", "follower stays high", toneN, 1);
    waitStrobe(g);
    sel12 = 1'b1;
  endtask

  task automatic testSystem12();
    int g;
    waitStrobe(g);
    chk("R5", "idle strobe spacing 12k", g, TMO12);
    pushPacket(P12, 0, 0);
    pushPacket(P12, 0, 0);
    periodQ.push_back(P12);
    waitStrobe(g);
    chk("R2", "12k tone packet good", pktGood, 1);
    chk("R6", "12k first packet follower high", toneN, 1);
    waitStrobe(g);
    chk("R2", "12k packet spacing", g, 32 * P12);
    chk("R2", "12k follower low", toneN, 0);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin : mainSeq
    rstN = 1'b0;
    sel12 = 1'b0;
    repeat (5) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "toneN after reset", toneN, 1);
    lastStamp = cyc;
    testIdle();
    testToneOn16();
    testThreshold();
    testWrongRate();
    testSystem12();
    chk("R8", "follower moves only with strobe", r8Bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule